// File: doc/BRIEF.md
# Channel State Store with SECDED and Parity Injection

This block keeps the per-channel state of a multi-channel transfer engine in a small ECC-protected word store. Each channel owns two 32-bit words. The first holds the control field group (priority, non-secure flag, bufferable flag, protection context, preemptable flag) and the X/Y loop indices. The second holds the current descriptor pointer. Every stored entry carries 7 SECDED check bits, so an entry is 39 bits wide.

A single write port takes either a field write or a raw full-word write. A field write changes only the bits of its own field group. The block reads the old word, corrects it, merges the new bits, recomputes the check bits and writes the result back. The write port stalls for one cycle while this happens. A raw write replaces a whole word and can also be used to initialise the store. When injection is armed and a raw write hits the programmed word address, the supplied parity is stored in place of the computed check bits. This lets software plant single-bit and double-bit faults.

A separate read port returns corrected data one cycle after the request. It pulses a single-error or double-error flag with the data and latches the word address that failed.

Top module: `chan_state_ram`

## Requirements
- R1: Channel i's word 0 is at store address 2*i and its word 1 is at 2*i+1. A raw write of kind 3 goes to word 0 and a raw write of kind 4 goes to word 1; for example, kind 4 on channel 6 lands at address 13.
- R2: After reset, every word reads as 0 with no error flag. After reset, wr_ready_o is 1 and rd_valid_o, sec_err_o, ded_err_o and addr_err_o are 0.
- R3: Field writes act on the bits selected by their mask and preserve all other bits of the word:
  - kind 0 (control) writes bits [8:0] of word 0.
  - kind 1 (index) writes bits [31:16] of word 0.
  - kind 2 (pointer) writes bits [31:2] of word 1.
- R4: An accepted field write drives wr_ready_o low for exactly the next cycle. An accepted raw write does not lower wr_ready_o.
- R5: A read request to address A gives rd_valid_o and rd_data_o on the cycle after the request.
- R6: A raw write made while inj_en_i=1 and its word address equals inj_addr_i stores inj_parity_i as the check bits. The check bits of all-zero data are zero.
- R7: A raw write stores computed check bits when inj_en_i=0 or when its word address differs from inj_addr_i.
- R8: A field write never uses the injected parity, even when the address matches and injection is armed.
- R9: When the syndrome of a read has odd weight and names a data or check bit, rd_data_o is corrected and sec_err_o pulses for that one cycle. A single flipped check bit of all-zero data returns 0 with sec_err_o=1.
- R10: When the syndrome is nonzero but not correctable, ded_err_o pulses with the read. Two flipped check bits are an example. sec_err_o and ded_err_o are never high together.
- R11: From the cycle after an error pulse, err_addr_o holds the address of that read until the next error.
- R12: Each of the following is ignored and gives an addr_err_o pulse on the next cycle, with no store change and no rd_valid_o:
  - a raw or field write with wr_chan_i >= NUM_CH;
  - a read with rd_addr_i >= 2*NUM_CH.

  Kind codes 5 to 7 are ignored.
- R13: A field write to a word that holds a single-bit error stores the corrected, merged data with fresh check bits, so a later read shows no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write request |
| wr_kind_i | input | 3 | 0 control, 1 index, 2 pointer, 3 raw word 0, 4 raw word 1 |
| wr_chan_i | input | CH_W | Channel number |
| wr_data_i | input | 32 | Write data, fields at their word bit positions |
| wr_ready_o | output | 1 | Write port can accept a request |
| inj_en_i | input | 1 | Injection armed |
| inj_addr_i | input | WA_W | Target word address for injection |
| inj_parity_i | input | 7 | Check bits to store on injection |
| rd_valid_i | input | 1 | Read request |
| rd_addr_i | input | WA_W | Read word address |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Corrected read data |
| sec_err_o | output | 1 | Corrected single-bit error pulse |
| ded_err_o | output | 1 | Uncorrectable error pulse |
| err_addr_o | output | WA_W | Address of the last failing read |
| addr_err_o | output | 1 | Out-of-range request pulse |

## Verification
On every cycle, the assertions check the following:
- the write handshake: one stall cycle after a field write, and never two stall cycles in a row;
- one-cycle read valid timing;
- that error pulses appear only with read data and never both at once;
- that the failing address is latched;
- that out-of-range reads are flagged.

Only the directed scenarios can show data results:
- the channel-to-address mapping;
- that field merges preserve the other bits;
- that planted parity yields the expected error class;
- that field writes ignore an armed injection and scrub a faulty word;
- that ignored out-of-range writes leave the store untouched.

// File: rtl/chan_state_pkg.sv
package chan_state_pkg;
  localparam int DW = 32;
  localparam int CW = 7;
  localparam int EW = DW + CW;

  typedef enum logic [2:0] {
    WK_CTRL = 3'd0,
    WK_IDX  = 3'd1,
    WK_PTR  = 3'd2,
    WK_RAW0 = 3'd3,
    WK_RAW1 = 3'd4
  } wr_kind_e;

  localparam logic [DW-1:0] CTRL_MASK = 32'h0000_01FF;
  localparam logic [DW-1:0] IDX_MASK  = 32'hFFFF_0000;
  localparam logic [DW-1:0] PTR_MASK  = 32'hFFFF_FFFC;

  // Hsiao columns: the first DW weight-3 patterns in ascending order
  function automatic logic [DW-1:0][CW-1:0] build_cols();
    logic [DW-1:0][CW-1:0] t;
    int n;
    t = '0;
    n = 0;
    for (int v = 1; v < (1 << CW); v++) begin
      logic [CW-1:0] b;
      b = CW'(v);
      if ($countones(b) == 3 && n < DW) begin
        t[n] = b;
        n++;
      end
    end
    return t;
  endfunction

  localparam logic [DW-1:0][CW-1:0] H_COLS = build_cols();
endpackage

// File: rtl/cs_ecc_enc.sv
module cs_ecc_enc
  import chan_state_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] check_o
);
  always_comb begin
    check_o = '0;
    for (int i = 0; i < DW; i++)
      if (data_i[i]) check_o = check_o ^ H_COLS[i];
  end
endmodule

// File: rtl/cs_ecc_dec.sv
module cs_ecc_dec
  import chan_state_pkg::*;
(
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] check_i,
  output logic [DW-1:0] data_o,
  output logic          sec_o,
  output logic          ded_o
);
  logic [CW-1:0] calc;
  logic [CW-1:0] syn;
  logic [DW-1:0] flip;
  logic          single;

  cs_ecc_enc u_enc (.data_i(data_i), .check_o(calc));

  assign syn = calc ^ check_i;

  for (genvar gi = 0; gi < DW; gi++) begin : g_flip
    assign flip[gi] = (syn == H_COLS[gi]);
  end

  assign single = (|flip) || ($countones(syn) == 1);
  assign data_o = data_i ^ (single ? flip : '0);
  assign sec_o  = single;
  assign ded_o  = (syn != '0) && !single;
endmodule

// File: rtl/cs_word_store.sv
module cs_word_store #(
  parameter int WORDS = 16,
  parameter int IW    = 4,
  parameter int EW    = 39
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [EW-1:0] wdata_i,
  input  logic          ra_en_i,
  input  logic [IW-1:0] ra_addr_i,
  output logic [EW-1:0] ra_q_o,
  input  logic          rb_en_i,
  input  logic [IW-1:0] rb_addr_i,
  output logic [EW-1:0] rb_q_o
);
  logic [EW-1:0] mem [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ra_q_o <= '0;
      rb_q_o <= '0;
    end else begin
      if (ra_en_i) ra_q_o <= mem[ra_addr_i];
      if (rb_en_i) rb_q_o <= mem[rb_addr_i];
    end
  end
endmodule

// File: rtl/chan_state_ram.sv
module chan_state_ram
  import chan_state_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int WORDS = 2 * NUM_CH,
  localparam int IW    = $clog2(WORDS),
  localparam int WA_W  = IW + 1,
  localparam int CH_W  = WA_W - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_valid_i,
  input  logic [2:0]      wr_kind_i,
  input  logic [CH_W-1:0] wr_chan_i,
  input  logic [31:0]     wr_data_i,
  output logic            wr_ready_o,
  input  logic            inj_en_i,
  input  logic [WA_W-1:0] inj_addr_i,
  input  logic [6:0]      inj_parity_i,
  input  logic            rd_valid_i,
  input  logic [WA_W-1:0] rd_addr_i,
  output logic            rd_valid_o,
  output logic [31:0]     rd_data_o,
  output logic            sec_err_o,
  output logic            ded_err_o,
  output logic [WA_W-1:0] err_addr_o,
  output logic            addr_err_o
);
  localparam logic [CH_W-1:0] CH_LIM   = CH_W'(NUM_CH);
  localparam logic [WA_W-1:0] WORD_LIM = WA_W'(WORDS);

  logic            wr_fire, chan_ok, is_raw, is_field, sel_w1;
  logic [WA_W-1:0] wr_addr;
  logic [DW-1:0]   wr_mask;
  logic            rmw_busy_q;
  logic [WA_W-1:0] rmw_addr_q;
  logic [DW-1:0]   rmw_mask_q, rmw_data_q;
  logic [EW-1:0]   rmw_raw, rd_raw;
  logic [DW-1:0]   rmw_fix, merged, enc_data;
  logic            rmw_sec_unused, rmw_ded_unused;
  logic [CW-1:0]   enc_check, st_check;
  logic            st_we;
  logic [WA_W-1:0] st_addr;
  logic            rd_ok, rd_vld_q;
  logic [WA_W-1:0] rd_addr_q, err_addr_q;
  logic            addr_err_q;
  logic            dec_sec, dec_ded;

  assign wr_ready_o = !rmw_busy_q;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign chan_ok    = wr_chan_i < CH_LIM;
  assign is_raw     = (wr_kind_i == WK_RAW0) || (wr_kind_i == WK_RAW1);
  assign is_field   = (wr_kind_i == WK_CTRL) || (wr_kind_i == WK_IDX) ||
                      (wr_kind_i == WK_PTR);
  assign sel_w1     = (wr_kind_i == WK_RAW1) || (wr_kind_i == WK_PTR);
  assign wr_addr    = {wr_chan_i, sel_w1};

  always_comb begin
    unique case (wr_kind_i)
      WK_CTRL: wr_mask = CTRL_MASK;
      WK_IDX:  wr_mask = IDX_MASK;
      WK_PTR:  wr_mask = PTR_MASK;
      default: wr_mask = '1;
    endcase
  end

  // read-modify-write capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rmw_busy_q <= 1'b0;
      rmw_addr_q <= '0;
      rmw_mask_q <= '0;
      rmw_data_q <= '0;
    end else if (rmw_busy_q) begin
      rmw_busy_q <= 1'b0;
    end else if (wr_fire && is_field && chan_ok) begin
      rmw_busy_q <= 1'b1;
      rmw_addr_q <= wr_addr;
      rmw_mask_q <= wr_mask;
      rmw_data_q <= wr_data_i;
    end
  end

  cs_ecc_dec u_rmw_dec (
    .data_i (rmw_raw[DW-1:0]),
    .check_i(rmw_raw[EW-1:DW]),
    .data_o (rmw_fix),
    .sec_o  (rmw_sec_unused),
    .ded_o  (rmw_ded_unused)
  );

  assign merged   = (rmw_fix & ~rmw_mask_q) | (rmw_data_q & rmw_mask_q);
  assign enc_data = rmw_busy_q ? merged : wr_data_i;

  cs_ecc_enc u_enc (.data_i(enc_data), .check_o(enc_check));

  // injection applies to raw full-word writes only
  assign st_check = (!rmw_busy_q && inj_en_i && inj_addr_i == wr_addr) ?
                    inj_parity_i : enc_check;
  assign st_we    = rmw_busy_q || (wr_fire && is_raw && chan_ok);
  assign st_addr  = rmw_busy_q ? rmw_addr_q : wr_addr;

  assign rd_ok = rd_valid_i && (rd_addr_i < WORD_LIM);

  cs_word_store #(.WORDS(WORDS), .IW(IW), .EW(EW)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (st_we),
    .waddr_i  (st_addr[IW-1:0]),
    .wdata_i  ({st_check, enc_data}),
    .ra_en_i  (rd_ok),
    .ra_addr_i(rd_addr_i[IW-1:0]),
    .ra_q_o   (rd_raw),
    .rb_en_i  (wr_fire && is_field && chan_ok),
    .rb_addr_i(wr_addr[IW-1:0]),
    .rb_q_o   (rmw_raw)
  );

  cs_ecc_dec u_rd_dec (
    .data_i (rd_raw[DW-1:0]),
    .check_i(rd_raw[EW-1:DW]),
    .data_o (rd_data_o),
    .sec_o  (dec_sec),
    .ded_o  (dec_ded)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q   <= 1'b0;
      rd_addr_q  <= '0;
      err_addr_q <= '0;
      addr_err_q <= 1'b0;
    end else begin
      rd_vld_q <= rd_ok;
      if (rd_ok) rd_addr_q <= rd_addr_i;
      if (rd_vld_q && (dec_sec || dec_ded)) err_addr_q <= rd_addr_q;
      addr_err_q <= (wr_fire && (is_raw || is_field) && !chan_ok) ||
                    (rd_valid_i && !rd_ok);
    end
  end

  assign rd_valid_o = rd_vld_q;
  assign sec_err_o  = rd_vld_q && dec_sec;
  assign ded_err_o  = rd_vld_q && dec_ded;
  assign err_addr_o = err_addr_q;
  assign addr_err_o = addr_err_q;
endmodule

// File: rtl/chan_state_checker.sv
module chan_state_checker #(
  parameter int NUM_CH = 8,
  parameter int WA_W   = 5,
  parameter int CH_W   = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_valid_i,
  input logic [2:0]      wr_kind_i,
  input logic [CH_W-1:0] wr_chan_i,
  input logic            wr_ready_o,
  input logic            rd_valid_i,
  input logic [WA_W-1:0] rd_addr_i,
  input logic            rd_valid_o,
  input logic            sec_err_o,
  input logic            ded_err_o,
  input logic [WA_W-1:0] err_addr_o,
  input logic            addr_err_o
);
  localparam logic [CH_W-1:0] CH_LIM   = CH_W'(NUM_CH);
  localparam logic [WA_W-1:0] WORD_LIM = WA_W'(2 * NUM_CH);

  a_r4_field_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o && wr_kind_i <= 3'd2 && wr_chan_i < CH_LIM)
      |=> !wr_ready_o);

  a_r4_stall_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ready_o |=> wr_ready_o);

  a_r5_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_addr_i < WORD_LIM) |=> rd_valid_o);

  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_i && rd_addr_i < WORD_LIM) |=> !rd_valid_o);

  a_r9_err_with_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_err_o || ded_err_o) |-> rd_valid_o);

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sec_err_o && ded_err_o));

  a_r11_err_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_err_o || ded_err_o) |=> err_addr_o == $past(rd_addr_i, 2));

  a_r12_read_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_addr_i >= WORD_LIM) |=> addr_err_o);
endmodule

bind chan_state_ram chan_state_checker #(
  .NUM_CH(NUM_CH), .WA_W(WA_W), .CH_W(CH_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_valid_i(wr_valid_i),
  .wr_kind_i (wr_kind_i),
  .wr_chan_i (wr_chan_i),
  .wr_ready_o(wr_ready_o),
  .rd_valid_i(rd_valid_i),
  .rd_addr_i (rd_addr_i),
  .rd_valid_o(rd_valid_o),
  .sec_err_o (sec_err_o),
  .ded_err_o (ded_err_o),
  .err_addr_o(err_addr_o),
  .addr_err_o(addr_err_o)
);

// File: tb/chan_state_ram_test.sv
`timescale 1ns/1ps
module chan_state_ram_test;
  localparam int NUM_CH = 8;
  localparam int WA_W = 5;
  localparam int CH_W = 4;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_valid_i = 1'b0;
  logic [2:0]      wr_kind_i = '0;
  logic [CH_W-1:0] wr_chan_i = '0;
  logic [31:0]     wr_data_i = '0;
  logic            wr_ready_o;
  logic            inj_en_i = 1'b0;
  logic [WA_W-1:0] inj_addr_i = '0;
  logic [6:0]      inj_parity_i = '0;
  logic            rd_valid_i = 1'b0;
  logic [WA_W-1:0] rd_addr_i = '0;
  logic            rd_valid_o;
  logic [31:0]     rd_data_o;
  logic            sec_err_o, ded_err_o, addr_err_o;
  logic [WA_W-1:0] err_addr_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  chan_state_ram #(.NUM_CH(NUM_CH)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid_i), .wr_kind_i(wr_kind_i), .wr_chan_i(wr_chan_i),
    .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o),
    .inj_en_i(inj_en_i), .inj_addr_i(inj_addr_i), .inj_parity_i(inj_parity_i),
    .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .sec_err_o(sec_err_o), .ded_err_o(ded_err_o),
    .err_addr_o(err_addr_o), .addr_err_o(addr_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic raw_wr(input logic [2:0] kind, input logic [CH_W-1:0] ch, input logic [31:0] d);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_kind_i = kind; wr_chan_i = ch; wr_data_i = d;
    @(negedge clk);
    wr_valid_i = 1'b0;
    chk("R4 raw no stall", 32'(wr_ready_o), 32'd1);
  endtask

  task automatic field_wr(input logic [2:0] kind, input logic [CH_W-1:0] ch, input logic [31:0] d);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_kind_i = kind; wr_chan_i = ch; wr_data_i = d;
    @(negedge clk);
    wr_valid_i = 1'b0;
    chk("R4 stall cycle", 32'(wr_ready_o), 32'd0);
    @(negedge clk);
    chk("R4 ready again", 32'(wr_ready_o), 32'd1);
  endtask

  task automatic rd(input string req, input logic [WA_W-1:0] a, input logic [31:0] exp,
                    input logic exp_sec, input logic exp_ded);
    @(negedge clk);
    rd_valid_i = 1'b1; rd_addr_i = a;
    @(negedge clk);
    rd_valid_i = 1'b0;
    chk({req, " R5 valid"}, 32'(rd_valid_o), 32'd1);
    chk({req, " data"}, rd_data_o, exp);
    chk({req, " R9 sec"}, 32'(sec_err_o), 32'(exp_sec));
    chk({req, " R10 ded"}, 32'(ded_err_o), 32'(exp_ded));
    @(negedge clk);
    chk({req, " R9 pulse ends"}, 32'(sec_err_o | ded_err_o), 32'd0);
    if (exp_sec || exp_ded) chk({req, " R11 err addr"}, 32'(err_addr_o), 32'(a));
  endtask

  task automatic t_reset();
    chk("R2 ready", 32'(wr_ready_o), 32'd1);
    chk("R2 rd_valid", 32'(rd_valid_o), 32'd0);
    chk("R2 flags", 32'({sec_err_o, ded_err_o, addr_err_o}), 32'd0);
    rd("R2 word0", 5'd0, 32'h0, 1'b0, 1'b0);
    rd("R2 word15", 5'd15, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_map();
    raw_wr(3'd4, 4'd6, 32'hCAFE_0013);
    rd("R1 ch6 w1 at 13", 5'd13, 32'hCAFE_0013, 1'b0, 1'b0);
    raw_wr(3'd3, 4'd6, 32'hBEEF_0012);
    rd("R1 ch6 w0 at 12", 5'd12, 32'hBEEF_0012, 1'b0, 1'b0);
    rd("R1 w1 kept", 5'd13, 32'hCAFE_0013, 1'b0, 1'b0);
  endtask

  task automatic t_field();
    raw_wr(3'd3, 4'd1, 32'h1234_5678);
    raw_wr(3'd4, 4'd1, 32'h8765_4321);
    field_wr(3'd0, 4'd1, 32'hFFFF_FFFF);
    rd("R3 ctrl merge", 5'd2, 32'h1234_57FF, 1'b0, 1'b0);
    field_wr(3'd1, 4'd1, 32'h0000_0000);
    rd("R3 idx merge", 5'd2, 32'h0000_57FF, 1'b0, 1'b0);
    field_wr(3'd2, 4'd1, 32'h0000_0000);
    rd("R3 ptr merge", 5'd3, 32'h0000_0001, 1'b0, 1'b0);
  endtask

  task automatic t_inject();
    inj_en_i = 1'b1; inj_addr_i = 5'd4; inj_parity_i = 7'h01;
    raw_wr(3'd3, 4'd2, 32'h0);
    rd("R6 R9 single parity", 5'd4, 32'h0, 1'b1, 1'b0);
    inj_addr_i = 5'd5; inj_parity_i = 7'h03;
    raw_wr(3'd4, 4'd2, 32'h0);
    rd("R6 R10 double parity", 5'd5, 32'h0, 1'b0, 1'b1);
    inj_en_i = 1'b0; inj_addr_i = 5'd6; inj_parity_i = 7'h01;
    raw_wr(3'd3, 4'd3, 32'h0);
    rd("R7 disarmed", 5'd6, 32'h0, 1'b0, 1'b0);
    inj_en_i = 1'b1; inj_addr_i = 5'd7;
    raw_wr(3'd3, 4'd3, 32'h0);
    rd("R7 other addr", 5'd6, 32'h0, 1'b0, 1'b0);
    inj_en_i = 1'b0;
  endtask

  task automatic t_field_no_inj();
    raw_wr(3'd3, 4'd4, 32'h0);
    inj_en_i = 1'b1; inj_addr_i = 5'd8; inj_parity_i = 7'h03;
    field_wr(3'd0, 4'd4, 32'h0000_01FF);
    rd("R8 field ignores inject", 5'd8, 32'h0000_01FF, 1'b0, 1'b0);
    inj_en_i = 1'b0;
  endtask

  task automatic t_scrub();
    field_wr(3'd0, 4'd2, 32'h0000_0005);
    rd("R13 scrubbed", 5'd4, 32'h0000_0005, 1'b0, 1'b0);
  endtask

  task automatic t_range();
    @(negedge clk);
    wr_valid_i = 1'b1; wr_kind_i = 3'd3; wr_chan_i = 4'd8; wr_data_i = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_valid_i = 1'b0;
    chk("R12 write flag", 32'(addr_err_o), 32'd1);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_kind_i = 3'd0; wr_chan_i = 4'd9; wr_data_i = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_valid_i = 1'b0;
    chk("R12 field flag", 32'(addr_err_o), 32'd1);
    chk("R12 no stall", 32'(wr_ready_o), 32'd1);
    rd("R12 word0 untouched", 5'd0, 32'h0, 1'b0, 1'b0);
    rd("R12 word3 untouched", 5'd3, 32'h0000_0001, 1'b0, 1'b0);
    @(negedge clk);
    rd_valid_i = 1'b1; rd_addr_i = 5'd16;
    @(negedge clk);
    rd_valid_i = 1'b0;
    chk("R12 read flag", 32'(addr_err_o), 32'd1);
    chk("R12 no read valid", 32'(rd_valid_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_field();
    t_inject();
    t_field_no_inj();
    t_scrub();
    t_range();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule